// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This controller sits in the always-on domain and runs from a 32768 Hz slow clock. Software reaches it through a small 32-bit register bus with four word locations. A shutdown request drops the `pwr_en` output, which gates the main supply. The request only takes effect when the written word carries the correct password byte in its top eight bits, so a stray write cannot switch the chip off.

While the chip is shut down, the controller watches a set of already debounced wake-up pins and an RTC alarm line. Each pin has its own enable bit and its own polarity bit. When an enabled source becomes active, `pwr_en` rises again and the cause is recorded in a status word. After the next boot, software reads that word, and the read clears it. The debounce period selector is stored here and driven out to the external debouncer on `dbc_sel`.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1 and `dbc_sel` is 0. The registers at offsets 0x0, 0x4, 0x8 and 0xC all read 0.
- R2: In the powered state, a write to offset 0x0 with bits [31:24] = 0xA5 and bit 0 = 1 drives `pwr_en` to 0 from the next cycle on.
- R3: A write to offset 0x0 with any other key byte, or with bit 0 = 0, leaves `pwr_en` unchanged.
- R4: Offset 0x4 keeps only bits [26:24], the debounce selector driven on `dbc_sel`, and bit 17, the RTC wake enable. All other bits read as 0.
- R5: Offset 0xC reads back as written. Bit i (i < 16) enables wake pin i, and bit 16+i selects the polarity of pin i: 1 means active high, 0 means active low.
- R6: In the shutdown state, an enabled pin at its active level raises `pwr_en` in the next cycle and sets status bit 16+i.
- R7: A disabled pin, or a pin at its inactive level, has no effect.
- R8: In shutdown, `rtc_alarm` = 1 with offset 0x4 bit 17 set wakes the chip and sets status bit 5. With bit 17 clear, the alarm is ignored.
- R9: The status word at offset 0x8 is presented combinationally while a read is requested, and it clears at the end of that read cycle. An event captured in the same cycle as the read is kept for the next read.
- R10: In the powered state, wake sources set no status bits and do not affect `pwr_en`.
- R11: Offset 0x0 and all unmapped offsets read as 0. Writes to unmapped offsets and to offset 0x8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wake_in | input | 16 | Debounced wake-up pins |
| rtc_alarm | input | 1 | RTC alarm level |
| dbc_sel | output | 3 | Debounce period selector for the external debouncer |
| pwr_en | output | 1 | Main supply enable, 1 = powered |

## Verification
A stuck or wrong power state appears on `pwr_en` one cycle after the edge that should have changed it. A wrong key decode, for example, shows up as a missing or a spurious shutdown on the very next cycle. A corrupted status register or configuration register shows up the first time that register is read. For that reason the random stream mixes status reads densely with shutdowns and wake events. A polarity or enable bit that is decoded wrongly shows up either as a wake that does not happen (`pwr_en` stays 0) or as an early wake with unexpected status bits.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_MODE = 4'h4;
  localparam logic [3:0] ADDR_STAT = 4'h8;
  localparam logic [3:0] ADDR_WCFG = 4'hC;
  localparam logic [7:0] SHDN_KEY  = 8'hA5;
  localparam int KEY_LSB      = 24;
  localparam int DBC_LSB      = 24;
  localparam int MODE_RTC_BIT = 17;
  localparam int STAT_RTC_BIT = 5;
  localparam int STAT_PIN_LSB = 16;
  localparam int POL_LSB      = 16;

  typedef enum logic {ST_ON = 1'b0, ST_OFF = 1'b1} pwr_state_e;

  // Key byte check plus command bit
  function automatic logic shdn_cmd_ok(input logic [31:0] w);
    return (w[KEY_LSB +: 8] == SHDN_KEY) && w[0];
  endfunction
endpackage

// File: rtl/pgc_cfg_regs.sv
module pgc_cfg_regs
  import pgc_pkg::*;
#(
  parameter int NW    = 16,
  parameter int DBC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_wcfg,
  input  logic [31:0]      wdata,
  output logic             rtc_en,
  output logic [DBC_W-1:0] dbc_sel,
  output logic [NW-1:0]    pin_en,
  output logic [NW-1:0]    pin_pol,
  output logic [31:0]      mode_word,
  output logic [31:0]      wcfg_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtc_en  <= 1'b0;
      dbc_sel <= '0;
    end else if (wr_mode) begin
      rtc_en  <= wdata[MODE_RTC_BIT];
      dbc_sel <= wdata[DBC_LSB +: DBC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en  <= '0;
      pin_pol <= '0;
    end else if (wr_wcfg) begin
      pin_en  <= wdata[NW-1:0];
      pin_pol <= wdata[POL_LSB +: NW];
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[MODE_RTC_BIT] = rtc_en;
    mode_word[DBC_LSB +: DBC_W] = dbc_sel;
    wcfg_word = '0;
    wcfg_word[NW-1:0] = pin_en;
    wcfg_word[POL_LSB +: NW] = pin_pol;
  end

  // R4
  rtc_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (rtc_en == $past(wdata[MODE_RTC_BIT])));
  // R5
  wcfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wcfg |=> (pin_en == $past(wdata[NW-1:0])));
endmodule

// File: rtl/pgc_wake_detect.sv
module pgc_wake_detect #(
  parameter int NW = 16
) (
  input  logic [NW-1:0] pins,
  input  logic [NW-1:0] pin_en,
  input  logic [NW-1:0] pin_pol,
  input  logic          rtc_en,
  input  logic          rtc_alarm,
  output logic [NW-1:0] pin_hit,
  output logic          rtc_hit,
  output logic          any_hit
);
  // Active level: pol=1 high, pol=0 low
  function automatic logic pin_active(input logic lvl, input logic pol, input logic en);
    return en && (lvl == pol);
  endfunction

  for (genvar i = 0; i < NW; i++) begin : g_pin
    assign pin_hit[i] = pin_active(pins[i], pin_pol[i], pin_en[i]);
  end

  assign rtc_hit = rtc_en && rtc_alarm;
  assign any_hit = (|pin_hit) || rtc_hit;
endmodule

// File: rtl/pgc_status.sv
module pgc_status
  import pgc_pkg::*;
#(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          rd_clr,
  input  logic [NW-1:0] pin_hit,
  input  logic          rtc_hit,
  output logic [31:0]   stat_word
);
  logic [NW-1:0] pin_q;
  logic          rtc_q;
  logic [NW-1:0] pin_cap;
  logic          rtc_cap;

  assign pin_cap = armed ? pin_hit : '0;
  assign rtc_cap = armed && rtc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      rtc_q <= 1'b0;
    end else begin
      pin_q <= (rd_clr ? '0 : pin_q) | pin_cap;
      rtc_q <= (rd_clr ? 1'b0 : rtc_q) | rtc_cap;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_PIN_LSB +: NW] = pin_q;
    stat_word[STAT_RTC_BIT] = rtc_q;
  end

  // R9
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !armed) |=> (stat_word == 32'd0));
  // R10
  powered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rd_clr) |=> $stable(stat_word));
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pgc_pkg::*;
#(
  parameter int NW    = 16,
  parameter int DBC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NW-1:0]    wake_in,
  input  logic             rtc_alarm,
  output logic [DBC_W-1:0] dbc_sel,
  output logic             pwr_en
);
  pwr_state_e    state_q;
  logic          ctrl_wr, mode_wr, wcfg_wr, stat_rd, cmd_ok;
  logic          rtc_en, rtc_hit, any_hit, armed;
  logic [NW-1:0] pin_en, pin_pol, pin_hit;
  logic [31:0]   mode_word, wcfg_word, stat_word;

  assign ctrl_wr = bus_en && bus_we && (bus_addr == ADDR_CTRL);
  assign mode_wr = bus_en && bus_we && (bus_addr == ADDR_MODE);
  assign wcfg_wr = bus_en && bus_we && (bus_addr == ADDR_WCFG);
  assign stat_rd = bus_en && !bus_we && (bus_addr == ADDR_STAT);
  assign cmd_ok  = shdn_cmd_ok(bus_wdata);
  assign armed   = (state_q == ST_OFF);

  pgc_cfg_regs #(.NW(NW), .DBC_W(DBC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_mode(mode_wr), .wr_wcfg(wcfg_wr),
    .wdata(bus_wdata), .rtc_en(rtc_en), .dbc_sel(dbc_sel),
    .pin_en(pin_en), .pin_pol(pin_pol),
    .mode_word(mode_word), .wcfg_word(wcfg_word)
  );

  pgc_wake_detect #(.NW(NW)) u_det (
    .pins(wake_in), .pin_en(pin_en), .pin_pol(pin_pol),
    .rtc_en(rtc_en), .rtc_alarm(rtc_alarm),
    .pin_hit(pin_hit), .rtc_hit(rtc_hit), .any_hit(any_hit)
  );

  pgc_status #(.NW(NW)) u_stat (
    .clk(clk), .rst_n(rst_n), .armed(armed), .rd_clr(stat_rd),
    .pin_hit(pin_hit), .rtc_hit(rtc_hit), .stat_word(stat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_ON;
    else if (armed && any_hit)
      state_q <= ST_ON;
    else if (!armed && ctrl_wr && cmd_ok)
      state_q <= ST_OFF;
  end

  assign pwr_en = (state_q == ST_ON);

  always_comb begin
    case (bus_addr)
      ADDR_MODE: bus_rdata = mode_word;
      ADDR_STAT: bus_rdata = stat_word;
      ADDR_WCFG: bus_rdata = wcfg_word;
      default:   bus_rdata = 32'd0;
    endcase
  end

  // R2
  key_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ctrl_wr && bus_wdata[31:24] == 8'hA5 && bus_wdata[0]) |=> !pwr_en);
  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ctrl_wr && !(bus_wdata[31:24] == 8'hA5 && bus_wdata[0])) |=> pwr_en);
  // R6
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && (|pin_hit || rtc_hit)) |=> pwr_en);
  // R7
  no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !any_hit) |=> !pwr_en);
endmodule

// File: tb/pwr_gate_ctrl_test.sv
module pwr_gate_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [15:0] wake_in = 16'h0000;
  logic        rtc_alarm = 1'b0;
  logic [2:0]  dbc_sel;
  logic        pwr_en;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_mode = 0, m_wcfg = 0, m_stat = 0, last_rd = 0;
  logic        m_pwr = 1'b1;

  pwr_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_in(wake_in), .rtc_alarm(rtc_alarm), .dbc_sel(dbc_sel), .pwr_en(pwr_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h4: return m_mode;
      4'h8: return m_stat;
      4'hC: return m_wcfg;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [15:0] m_pins(input logic [15:0] p);
    logic [15:0] h = 0;
    for (int i = 0; i < 16; i++)
      if (m_wcfg[i]) h[i] = m_wcfg[16+i] ? p[i] : !p[i];
    return h;
  endfunction

  // One bus cycle plus model update and checks
  task automatic cyc(input logic en, input logic we, input logic [3:0] a,
                     input logic [31:0] d, input logic [15:0] p, input logic rtc,
                     input string tag);
    logic [15:0] h;
    logic rh;
    logic [31:0] st_n;
    logic pw_n;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    wake_in = p; rtc_alarm = rtc;
    #1;
    if (en && !we) begin
      last_rd = bus_rdata;
      chk(bus_rdata, m_read(a), tag);
    end
    h = m_pins(p);
    rh = m_mode[17] && rtc;
    st_n = (en && !we && a == 4'h8) ? 32'd0 : m_stat;
    pw_n = m_pwr;
    if (!m_pwr) begin
      st_n = st_n | {h, 16'd0} | (32'(rh) << 5);
      if ((|h) || rh) pw_n = 1'b1;
    end else if (en && we && a == 4'h0 && d[31:24] == 8'hA5 && d[0]) pw_n = 1'b0;
    @(posedge clk);
    m_stat = st_n;
    m_pwr = pw_n;
    if (en && we && a == 4'h4) m_mode = d & 32'h0702_0000;
    if (en && we && a == 4'hC) m_wcfg = d;
    #1;
    chk({31'd0, pwr_en}, {31'd0, m_pwr}, tag);
    chk({29'd0, dbc_sel}, {29'd0, m_mode[26:24]}, "R4 dbc_sel");
    bus_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk({31'd0, pwr_en}, 32'd1, "R1 pwr_en");
    cyc(1, 0, 4'h4, 0, 16'h0000, 0, "R1 mode");
    cyc(1, 0, 4'hC, 0, 16'h0000, 0, "R1 wcfg");
    cyc(1, 0, 4'h8, 0, 16'h0000, 0, "R1 stat");
    chk(last_rd, 32'd0, "R1 stat zero");
    // R3 wrong key / no command bit
    cyc(1, 1, 4'h0, 32'hA400_0001, 16'h0000, 0, "R3 bad key");
    chk({31'd0, pwr_en}, 32'd1, "R3 bad key held");
    cyc(1, 1, 4'h0, 32'hA500_0000, 16'h0000, 0, "R3 no cmd bit");
    chk({31'd0, pwr_en}, 32'd1, "R3 no cmd held");
    // R4 mode mask
    cyc(1, 1, 4'h4, 32'hFFFF_FFFF, 16'h0000, 0, "R4 wr");
    cyc(1, 0, 4'h4, 0, 16'h0000, 0, "R4 rd");
    chk(last_rd, 32'h0702_0000, "R4 mask");
    // R5 wcfg: pin0 active high, pin1 active low
    cyc(1, 1, 4'hC, 32'h0001_0003, 16'h0002, 0, "R5 wr");
    cyc(1, 0, 4'hC, 0, 16'h0002, 0, "R5 rd");
    chk(last_rd, 32'h0001_0003, "R5 readback");
    // R11 control and unmapped read zero, stat write ignored
    cyc(1, 1, 4'h8, 32'hFFFF_FFFF, 16'h0002, 0, "R11 stat wr");
    cyc(1, 0, 4'h0, 0, 16'h0002, 0, "R11 ctrl rd");
    cyc(1, 0, 4'h6, 0, 16'h0002, 0, "R11 unmapped");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R11 stat");
    // R10 powered: sources active, nothing recorded
    cyc(0, 0, 4'h0, 0, 16'h0001, 1, "R10 active powered");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R10 stat");
    chk(last_rd, 32'd0, "R10 no status");
    // R2 keyed shutdown
    cyc(1, 1, 4'h0, 32'hA500_0001, 16'h0002, 0, "R2 shutdown");
    chk({31'd0, pwr_en}, 32'd0, "R2 off");
    // R7 disabled pin toggles
    cyc(0, 0, 4'h0, 0, 16'h8002, 0, "R7 disabled pin");
    chk({31'd0, pwr_en}, 32'd0, "R7 still off");
    // R8 rtc wake
    cyc(0, 0, 4'h0, 0, 16'h0002, 1, "R8 rtc wake");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R8 stat");
    chk(last_rd, 32'h0000_0020, "R8 rtc bit");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R9 cleared");
    chk(last_rd, 32'd0, "R9 zero after read");
    // R7 active-low pin 1
    cyc(1, 1, 4'h0, 32'hA500_0001, 16'h0002, 0, "R2 shutdown2");
    cyc(0, 0, 4'h0, 0, 16'h0000, 0, "R7 pin1 low");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R7 stat");
    chk(last_rd, 32'h0002_0000, "R7 pin1 bit");
    // R8 rtc disabled; R9 same-cycle capture
    cyc(1, 1, 4'h4, 32'h0, 16'h0002, 0, "R8 disable");
    cyc(1, 1, 4'h0, 32'hA500_0001, 16'h0002, 0, "R2 shutdown3");
    cyc(0, 0, 4'h0, 0, 16'h0002, 1, "R8 rtc ignored");
    chk({31'd0, pwr_en}, 32'd0, "R8 stays off");
    cyc(1, 0, 4'h8, 0, 16'h0003, 0, "R9 read with event");
    chk(last_rd, 32'd0, "R9 old value");
    cyc(1, 0, 4'h8, 0, 16'h0002, 0, "R9 kept");
    chk(last_rd, 32'h0001_0000, "R9 kept bit");
    // R6 all sources disabled, then enable pin3 while off
    cyc(1, 1, 4'hC, 32'h0, 16'h0002, 0, "R6 disable all");
    cyc(1, 1, 4'h0, 32'hA500_0001, 16'hFFFF, 1, "R6 shutdown");
    cyc(0, 0, 4'h0, 0, 16'h0000, 1, "R6 nothing enabled");
    chk({31'd0, pwr_en}, 32'd0, "R6 stays off");
    cyc(1, 1, 4'hC, 32'h0008_0008, 16'h0008, 0, "R6 enable pin3");
    cyc(0, 0, 4'h0, 0, 16'h0008, 0, "R6 wake pin3");
    chk({31'd0, pwr_en}, 32'd1, "R6 powered");
    cyc(1, 0, 4'h8, 0, 16'h0000, 0, "R6 stat");
    // Random mix
    begin
      logic [15:0] pins = 16'h0;
      for (int n = 0; n < 4000; n++) begin
        int r = $urandom_range(0, 99);
        logic rtc = ($urandom_range(0, 9) == 0);
        if ($urandom_range(0, 3) == 0) pins = pins ^ (16'h1 << $urandom_range(0, 15));
        if (r < 10)      cyc(1, 1, 4'h0, 32'hA500_0001 | ($urandom & 32'h00FF_FFFE), pins, rtc, "R2 rand");
        else if (r < 15) cyc(1, 1, 4'h0, $urandom, pins, rtc, "R3 rand");
        else if (r < 22) cyc(1, 1, 4'h4, $urandom, pins, rtc, "R4 rand");
        else if (r < 30) cyc(1, 1, 4'hC, $urandom, pins, rtc, "R5 rand");
        else if (r < 55) cyc(1, 0, 4'h8, 0, pins, rtc, "R9 rand");
        else if (r < 65) cyc(1, 0, 4'($urandom_range(0, 15)), 0, pins, rtc, "R11 rand");
        else if (r < 70) cyc(1, 1, 4'($urandom_range(0, 15)), $urandom, pins, rtc, "R11 rand wr");
        else             cyc(0, 0, 4'h0, 0, pins, rtc, "R6 rand");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule